// File: doc/BRIEF.md
# Read/Write Head Mode Controller

This block is the digital control core of a multi-head storage read/write front end. It holds the power-mode, head-index and write-drive configuration fields. A simple register port with an address, a data word and a write strobe loads these fields. From the fields, the sampled read/write select input and a two-bit group-select input, it drives three groups of outputs: one-hot head enables for reading and for writing, enables for the bias source, the write current source and the fault detectors, and the tri-state and writer-grounding controls for the shared outputs.

A small state machine follows the programmed mode and the read/write select. It enforces that writing is only entered from active read. When it leaves writing for an idle mode, it holds read-equivalent outputs for one cycle so that the current sources are off before the shared outputs are released. A dual-head option enables head x and head x+6 together while writing, and head x alone while reading.

Top module: `rwhead_mode_ctl`

## Requirements
- R1: After a synchronous active-low reset, all fields are cleared: mode sleep, head 0, voltage drive, and the dual-head disable bit is set. All head, source and detector enables are low, both output enables are low, and the writer is grounded.
- R2: The mode field is bits [1:0] at address 2. Its codes are 00 sleep, 01 standby and 10 active. Code 11 behaves exactly as sleep. A change of the field takes effect on the clock edge after the register write.
- R3: In active mode with the read/write select high, the block reads: bias, fault-detector and both output enables are high, the write current is off, and the writer is grounded.
- R4: From active read, a low read/write select enters write on the next edge: the write current and bias are on and the writer ground is released. A high select in write returns to read on the next edge.
- R5: Write is never entered from sleep or standby. A low select there is ignored. Switching the mode to active always passes through at least one read cycle first.
- R6: In sleep and standby, the bias, write current and fault detectors are off, the read-data and fault outputs are tri-stated (enables low), and the writer is grounded.
- R7: When the mode leaves active while writing, one cycle follows with read-equivalent outputs (bias and output enables high, write current off) before the idle outputs appear.
- R8: Outside dual-head mode, the head index (address 0, bits [3:0]) picks exactly one read head in read or one write head in write, as bit x of the enable vector. An index above 11 enables no head. Read and write head enables are never high together.
- R9: Dual-head mode is active when bit 2 at address 2 is low and both group-select bits are high. In that mode read enables head x only and write enables heads x and x+6, for x from 0 to 5. A larger index enables no head.
- R10: Bit 0 at address 1 selects the write-data drive type (0 voltage, 1 current) and appears on the drive-type output one edge after the register write. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| rd_wr_n | input | 1 | Read (high) / write (low) select |
| grp_sel | input | 2 | Group select; both high allows dual-head mode |
| rd_head_en | output | NUM_HEADS | One-hot read head enables |
| wr_head_en | output | NUM_HEADS | Write head enables (one, or two in dual-head mode) |
| bias_en | output | 1 | Read bias source enable |
| wcur_en | output | 1 | Write current source enable |
| flt_det_en | output | 1 | Fault detector enable |
| rd_out_oe | output | 1 | Read-data output drive enable (low = tri-state) |
| flt_out_oe | output | 1 | Fault output drive enable (low = tri-state) |
| writer_gnd | output | 1 | Force writer terminals to ground |
| wr_drive_cur | output | 1 | Write-data drive type, 1 = current |

## Verification
A wrong internal state shows at the ports within one cycle, because every output is decoded from the state register and the fields without further pipelining. A state machine that skips read when leaving idle raises the write current one edge after activation, not two. A missing exit cycle drops the output enables in the same cycle as the write current. A mis-decoded head index shows as the wrong bit, or a missing twin bit, on the next sample after the register write. The bench compares every output against a behavioural model each cycle, so any such slip is caught in the first cycle it occurs.

// File: rtl/rwh_pkg.sv
package rwh_pkg;
   typedef enum logic [2:0] {
      ST_SLEEP = 3'd0,
      ST_STBY  = 3'd1,
      ST_READ  = 3'd2,
      ST_WRITE = 3'd3,
      ST_WEXIT = 3'd4
   } rwh_state_e;

   typedef enum logic [1:0] {
      MD_SLEEP  = 2'b00,
      MD_STBY   = 2'b01,
      MD_ACTIVE = 2'b10,
      MD_RSVD   = 2'b11
   } rwh_mode_e;
endpackage

// File: rtl/rwh_regs.sv
module rwh_regs
   import rwh_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int HSEL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output rwh_mode_e         mode_o,
   output logic [HSEL_W-1:0] head_o,
   output logic              drive_cur_o,
   output logic              pair_n_o
);
   localparam logic [ADDR_W-1:0] A_HEAD = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2);
   localparam int MODE_LSB = 0;
   localparam int PAIR_BIT = 2;

   initial begin : p_param_check
      assert (DATA_W >= HSEL_W && DATA_W >= PAIR_BIT + 1)
         else $error("rwh_regs: DATA_W too narrow for the fields");
   end

   logic [1:0]        mode_q;
   logic [HSEL_W-1:0] head_q;
   logic              drv_q;
   logic              pair_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= 2'b00;
         head_q   <= '0;
         drv_q    <= 1'b0;
         pair_n_q <= 1'b1;
      end else if (we) begin
         case (addr)
            A_HEAD: head_q <= wdata[HSEL_W-1:0];
            A_CFG:  drv_q  <= wdata[0];
            A_MODE: begin
               mode_q   <= wdata[MODE_LSB +: 2];
               pair_n_q <= wdata[PAIR_BIT];
            end
            default: ;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   assign mode_o      = rwh_mode_e'(mode_q);
   assign head_o      = head_q;
   assign drive_cur_o = drv_q;
   assign pair_n_o    = pair_n_q;
endmodule

// File: rtl/rwh_fsm.sv
module rwh_fsm
   import rwh_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  rwh_mode_e  mode,
   input  logic       rd_wr_n,
   output rwh_state_e state_o
);
   rwh_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (mode)
         MD_ACTIVE: begin
            case (st_q)
               ST_READ:  if (!rd_wr_n) st_d = ST_WRITE;
               ST_WRITE: if (rd_wr_n)  st_d = ST_READ;
               default:  st_d = ST_READ;
            endcase
         end
         MD_STBY: st_d = (st_q == ST_WRITE) ? ST_WEXIT : ST_STBY;
         default: st_d = (st_q == ST_WRITE) ? ST_WEXIT : ST_SLEEP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_SLEEP;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

   AST_WRITE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WRITE) |-> ($past(st_q) == ST_READ || $past(st_q) == ST_WRITE)); // R5
   AST_NO_DIRECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SLEEP || st_q == ST_STBY) |-> ($past(st_q) != ST_WRITE)); // R7
endmodule

// File: rtl/rwh_head_dec.sv
module rwh_head_dec #(
   parameter int NUM_HEADS   = 12,
   parameter int HSEL_W      = 4,
   parameter int PAIR_OFFSET = 6,
   parameter bit DUAL_EN     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [HSEL_W-1:0]    head_sel,
   input  logic                 pair_mode,
   input  logic                 rd_act,
   input  logic                 wr_act,
   output logic [NUM_HEADS-1:0] rd_en,
   output logic [NUM_HEADS-1:0] wr_en
);
   initial begin : p_param_check
      assert (HSEL_W >= $clog2(NUM_HEADS))
         else $error("rwh_head_dec: HSEL_W cannot index all heads");
      assert (!DUAL_EN || (PAIR_OFFSET > 0 && 2 * PAIR_OFFSET <= NUM_HEADS))
         else $error("rwh_head_dec: PAIR_OFFSET does not fit NUM_HEADS");
   end

   logic pair_eff;
   logic pair_ok;

   if (DUAL_EN) begin : g_dual
      assign pair_eff = pair_mode;
      assign pair_ok  = head_sel < HSEL_W'(PAIR_OFFSET);
   end else begin : g_single
      logic unused_pair;
      assign unused_pair = pair_mode;
      assign pair_eff    = 1'b0;
      assign pair_ok     = 1'b0;
   end

   for (genvar i = 0; i < NUM_HEADS; i++) begin : g_head
      localparam logic [HSEL_W-1:0] IDX = HSEL_W'(i);
      logic self_hit;
      logic twin_hit;
      assign self_hit = (head_sel == IDX) && (!pair_eff || pair_ok);
      if (DUAL_EN && i >= PAIR_OFFSET) begin : g_twin
         assign twin_hit = pair_eff && pair_ok &&
                           (head_sel == HSEL_W'(i - PAIR_OFFSET));
      end else begin : g_no_twin
         assign twin_hit = 1'b0;
      end
      assign rd_en[i] = rd_act & self_hit;
      assign wr_en[i] = wr_act & (self_hit | twin_hit);
   end

   AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_en)); // R8
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !((|rd_en) && (|wr_en))); // R8
   AST_WR_PAIR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wr_en) <= 2); // R9
endmodule

// File: rtl/rwhead_mode_ctl.sv
module rwhead_mode_ctl
   import rwh_pkg::*;
#(
   parameter int NUM_HEADS   = 12,
   parameter int HSEL_W      = 4,
   parameter int PAIR_OFFSET = 6,
   parameter bit DUAL_EN     = 1'b1,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic                 rd_wr_n,
   input  logic [1:0]           grp_sel,
   output logic [NUM_HEADS-1:0] rd_head_en,
   output logic [NUM_HEADS-1:0] wr_head_en,
   output logic                 bias_en,
   output logic                 wcur_en,
   output logic                 flt_det_en,
   output logic                 rd_out_oe,
   output logic                 flt_out_oe,
   output logic                 writer_gnd,
   output logic                 wr_drive_cur
);
   rwh_mode_e         mode;
   rwh_state_e        state;
   logic [HSEL_W-1:0] head;
   logic              pair_n;
   logic              rd_act, wr_act, live;

   rwh_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HSEL_W(HSEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .mode_o(mode), .head_o(head), .drive_cur_o(wr_drive_cur), .pair_n_o(pair_n)
   );

   rwh_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rd_wr_n(rd_wr_n), .state_o(state)
   );

   assign rd_act = (state == ST_READ) || (state == ST_WEXIT);
   assign wr_act = (state == ST_WRITE);
   assign live   = rd_act || wr_act;

   rwh_head_dec #(
      .NUM_HEADS(NUM_HEADS), .HSEL_W(HSEL_W),
      .PAIR_OFFSET(PAIR_OFFSET), .DUAL_EN(DUAL_EN)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .head_sel(head),
      .pair_mode(!pair_n && (&grp_sel)),
      .rd_act(rd_act), .wr_act(wr_act),
      .rd_en(rd_head_en), .wr_en(wr_head_en)
   );

   assign bias_en    = live;
   assign flt_det_en = live;
   assign rd_out_oe  = live;
   assign flt_out_oe = live;
   assign wcur_en    = wr_act;
   assign writer_gnd = !wr_act;

   AST_WRITE_AFTER_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcur_en) |-> $past(bias_en)); // R5
   AST_RELEASE_AFTER_WCUR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_out_oe) |-> !$past(wcur_en)); // R7
   AST_GND_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_out_oe |-> (writer_gnd && !wcur_en && !bias_en)); // R6
endmodule

// File: tb/rwhead_mode_ctl_tb.sv
`timescale 1ns/1ps
module rwhead_mode_ctl_tb;
   localparam int NH = 12;
   localparam int S_SLEEP = 0, S_STBY = 1, S_READ = 2, S_WRITE = 3, S_WEXIT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic          rd_wr_n = 1'b1;
   logic [1:0]    grp_sel = 2'b00;
   logic [NH-1:0] rd_head_en, wr_head_en;
   logic bias_en, wcur_en, flt_det_en, rd_out_oe, flt_out_oe, writer_gnd, wr_drive_cur;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   rwhead_mode_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .rd_wr_n(rd_wr_n), .grp_sel(grp_sel),
      .rd_head_en(rd_head_en), .wr_head_en(wr_head_en), .bias_en(bias_en),
      .wcur_en(wcur_en), .flt_det_en(flt_det_en), .rd_out_oe(rd_out_oe),
      .flt_out_oe(flt_out_oe), .writer_gnd(writer_gnd), .wr_drive_cur(wr_drive_cur)
   );

   // behavioural reference model
   int m_state = S_SLEEP;
   int m_mode = 0;
   int m_head = 0;
   int m_drive = 0;
   int m_pairn = 1;

   always @(posedge clk) begin
      int nxt;
      if (!rst_n) begin
         m_state = S_SLEEP; m_mode = 0; m_head = 0; m_drive = 0; m_pairn = 1;
      end else begin
         if (m_mode == 2) begin
            if (m_state == S_READ) nxt = rd_wr_n ? S_READ : S_WRITE;
            else if (m_state == S_WRITE) nxt = rd_wr_n ? S_READ : S_WRITE;
            else nxt = S_READ;
         end else if (m_state == S_WRITE) nxt = S_WEXIT;
         else nxt = (m_mode == 1) ? S_STBY : S_SLEEP;
         m_state = nxt;
         if (reg_we) begin
            if (reg_addr == 0) m_head = int'(reg_wdata[3:0]);
            else if (reg_addr == 1) m_drive = int'(reg_wdata[0]);
            else if (reg_addr == 2) begin
               m_mode = int'(reg_wdata[1:0]);
               m_pairn = int'(reg_wdata[2]);
            end
         end
      end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [NH-1:0] e_rd, e_wr;
      bit rd_a, wr_a, live, dual, valid;
      string tag;
      rd_a = (m_state == S_READ) || (m_state == S_WEXIT);
      wr_a = (m_state == S_WRITE);
      live = rd_a || wr_a;
      dual = (m_pairn == 0) && (grp_sel == 2'b11);
      valid = dual ? (m_head < 6) : (m_head < NH);
      for (int h = 0; h < NH; h++) begin
         e_rd[h] = rd_a && valid && (h == m_head);
         e_wr[h] = wr_a && valid && ((h == m_head) || (dual && h == m_head + 6));
      end
      case (m_state)
         S_READ:  tag = "R3";
         S_WRITE: tag = "R4";
         S_WEXIT: tag = "R7";
         default: tag = "R6";
      endcase
      chk(dual ? "R9" : "R8", "rd_head_en", 32'(rd_head_en), 32'(e_rd));
      chk(dual ? "R9" : "R8", "wr_head_en", 32'(wr_head_en), 32'(e_wr));
      chk(tag, "bias_en", 32'(bias_en), 32'(live));
      chk(tag, "wcur_en", 32'(wcur_en), 32'(wr_a));
      chk(tag, "flt_det_en", 32'(flt_det_en), 32'(live));
      chk(tag, "rd_out_oe", 32'(rd_out_oe), 32'(live));
      chk(tag, "flt_out_oe", 32'(flt_out_oe), 32'(live));
      chk(tag, "writer_gnd", 32'(writer_gnd), 32'(!wr_a));
      chk("R10", "wr_drive_cur", 32'(wr_drive_cur), 32'(m_drive));
   endtask

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic wr_reg(logic [3:0] a, logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   initial begin : p_watchdog
      #100000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "bias_en", 32'(bias_en), 0);
      chk("R1", "rd_head_en", 32'(rd_head_en), 0);
      chk("R1", "writer_gnd", 32'(writer_gnd), 1);
      chk("R1", "wr_drive_cur", 32'(wr_drive_cur), 0);
      // R5 write request in sleep ignored
      rd_wr_n = 1'b0;
      tick(4);
      chk("R5", "wcur_en in sleep", 32'(wcur_en), 0);
      wr_reg(4'd2, 8'h05);           // standby, dual disabled
      tick(3);
      chk("R5", "wcur_en in standby", 32'(wcur_en), 0);
      chk("R6", "rd_out_oe in standby", 32'(rd_out_oe), 0);
      // R5 activation with write requested goes via read
      wr_reg(4'd2, 8'h06);
      tick();
      chk("R5", "first active cycle wcur_en", 32'(wcur_en), 0);
      chk("R5", "first active cycle bias_en", 32'(bias_en), 1);
      tick();
      chk("R4", "write entered", 32'(wcur_en), 1);
      // R8 head select while writing and reading
      wr_reg(4'd0, 8'h03);
      chk("R8", "wr head 3", 32'(wr_head_en), 32'h008);
      rd_wr_n = 1'b1;
      tick();
      chk("R4", "back to read", 32'(wcur_en), 0);
      chk("R8", "rd head 3", 32'(rd_head_en), 32'h008);
      wr_reg(4'd0, 8'h0B);
      wr_reg(4'd0, 8'h0C);
      chk("R8", "index 12 none", 32'(rd_head_en), 0);
      wr_reg(4'd1, 8'h01);
      chk("R10", "drive current", 32'(wr_drive_cur), 1);
      wr_reg(4'd3, 8'hFF);           // unused address
      chk("R10", "unused address", 32'(wr_drive_cur), 1);
      chk("R10", "unused address head", 32'(rd_head_en), 0);
      // R9 dual-head mode
      wr_reg(4'd0, 8'h02);
      wr_reg(4'd2, 8'h02);           // active, dual enabled
      grp_sel = 2'b11;
      tick();
      chk("R9", "dual read head", 32'(rd_head_en), 32'h004);
      rd_wr_n = 1'b0;
      tick();
      chk("R9", "dual write pair", 32'(wr_head_en), 32'h104);
      grp_sel = 2'b10;
      tick();
      chk("R9", "group not both high", 32'(wr_head_en), 32'h004);
      grp_sel = 2'b11;
      wr_reg(4'd0, 8'h05);
      chk("R9", "pair 5/11", 32'(wr_head_en), 32'h820);
      wr_reg(4'd0, 8'h07);
      chk("R9", "index 7 dual none", 32'(wr_head_en), 0);
      // R7 exit from write to standby
      wr_reg(4'd2, 8'h01);
      chk("R7", "still writing", 32'(wcur_en), 1);
      tick();
      chk("R7", "exit cycle wcur_en", 32'(wcur_en), 0);
      chk("R7", "exit cycle rd_out_oe", 32'(rd_out_oe), 1);
      tick();
      chk("R7", "idle after exit", 32'(rd_out_oe), 0);
      // R2 reserved code behaves as sleep, exit via read-equivalent cycle
      rd_wr_n = 1'b1;
      wr_reg(4'd2, 8'h06);
      tick();
      rd_wr_n = 1'b0;
      tick(2);
      wr_reg(4'd2, 8'h07);
      tick(3);
      chk("R2", "reserved as sleep bias", 32'(bias_en), 0);
      chk("R2", "reserved as sleep gnd", 32'(writer_gnd), 1);
      tick(4);
      chk("R5", "write ignored in reserved", 32'(wcur_en), 0);
      // R1 mid-run reset
      wr_reg(4'd2, 8'h02);
      tick(2);
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick();
      chk("R1", "reset clears drive", 32'(wr_drive_cur), 0);
      chk("R1", "reset idle", 32'(rd_out_oe), 0);
      tick(3);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule